// File: doc/BRIEF.md
# Smart card character transceiver

This block sends and receives single asynchronous characters over a one-wire, half-duplex card link of the ISO 7816 kind. A character on the wire is a low start bit, then seven or eight data bits, then one parity bit, then two high stop periods. Every bit lasts a fixed, parameterized number of system clocks, and the line rests high between characters. The host side is a small register-style port. It carries a transmit byte strobe, a received byte with a full flag and a read strobe, a sticky parity-error flag with a clear strobe, and a control word. The control word selects enable, bit order, level inversion, data length and parity sense.

Cards that use the inverse convention need two settings together: most-significant-bit-first order and complemented data levels. Parity is always worked out from the levels that actually appear on the wire and is never inverted itself. The 8-bit register value and the wire levels can therefore disagree on parity when inversion is combined with a 7-bit length. Each direction handles one character at a time. A control write that arrives while a character is in flight is dropped.

Top module: `sc_char_xcvr`

## Requirements
- R1: After synchronous reset, line_out is high, busy, rx_full and perr are low, and every control readback (st_en, st_msb, st_inv, st_len7, st_odd) is 0.
- R2: A transmitted frame is one low start bit, the data bits, one parity bit and two high stop periods, each BIT_CLKS clocks long, and the line is high whenever busy is low.
- R3: With st_msb=0, data bits go out and are stored least significant first. With st_msb=1 they go out most significant first, and the receiver puts the first received bit in byte bit 7.
- R4: With st_len7=1 only seven data bits are framed. In LSB-first order bit 7 of tx_byte is not sent. In MSB-first order bit 0 is not sent. The receiver stores the unused bit position as 0.
- R5: With st_inv=1 each data bit is complemented on the line when sent and complemented again before it is stored. The parity bit level is never complemented.
- R6: The parity bit is computed over the line levels of the data bits. With st_odd=0 the number of high levels among the data bits plus parity is even. With st_odd=1 it is odd.
- R7: The receiver starts on a falling edge of line_in, samples each bit at mid-period and, after the parity bit, stores the byte into rx_byte and sets rx_full. An rx_rd pulse clears rx_full.
- R8: A received parity bit that differs from the computed one sets perr. perr stays set through later good characters until a perr_clr pulse.
- R9: busy rises on an accepted tx_wr and falls when the last stop period ends. A tx_wr while busy is ignored and does not change the frame in progress.
- R10: cfg_wr loads the five control bits only while no character is being sent or received, and is ignored otherwise.
- R11: With st_en=0 a tx_wr starts no frame and a character on line_in sets neither rx_full nor perr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_en | input | 1 | Enable value for the control write |
| cfg_msb | input | 1 | 1 = MSB-first order |
| cfg_inv | input | 1 | 1 = complement data levels |
| cfg_len7 | input | 1 | 1 = seven data bits, 0 = eight |
| cfg_odd | input | 1 | 1 = odd parity, 0 = even |
| tx_wr | input | 1 | Transmit byte strobe |
| tx_byte | input | 8 | Byte to transmit |
| busy | output | 1 | Transmit frame in progress |
| line_out | output | 1 | Serial line driven toward the card |
| line_in | input | 1 | Serial line received from the card |
| rx_rd | input | 1 | Received byte read strobe |
| rx_byte | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| perr | output | 1 | Sticky receive parity error |
| perr_clr | input | 1 | Clears perr |
| st_en | output | 1 | Current enable |
| st_msb | output | 1 | Current bit order |
| st_inv | output | 1 | Current inversion |
| st_len7 | output | 1 | Current data length |
| st_odd | output | 1 | Current parity sense |

## Verification
Eight control/byte patterns run through both directions. They cover plain LSB-first, inversion alone, MSB-first alone, the full inverse convention, and both orders at seven bits with and without inversion. Seven-bit inverted patterns are chosen so that parity over the register value and parity over the wire levels disagree, which exposes a parity taken from the wrong side of the inverter. The MSB-first seven-bit cases show which end of the byte is dropped, and asymmetric bytes such as 0x3B separate a reversed order from a plain one. Directed runs add a wrong parity bit, a transmit and a control write issued mid-frame, and a fully disabled block.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic en;
    logic msb;
    logic inv;
    logic len7;
    logic odd;
  } sc_cfg_t;

  function automatic logic [BYTE_W-1:0] len_mask(input sc_cfg_t c);
    return c.len7 ? {1'b0, {(BYTE_W-1){1'b1}}} : {BYTE_W{1'b1}};
  endfunction

  // Register byte -> line levels in send order (index 0 goes first)
  function automatic logic [BYTE_W-1:0] byte_to_line(input logic [BYTE_W-1:0] d, input sc_cfg_t c);
    logic [BYTE_W-1:0] r;
    for (int i = 0; i < BYTE_W; i++) r[i] = c.msb ? d[BYTE_W-1-i] : d[i];
    return (r ^ {BYTE_W{c.inv}}) & len_mask(c);
  endfunction

  // Line levels in arrival order -> register byte
  function automatic logic [BYTE_W-1:0] line_to_byte(input logic [BYTE_W-1:0] l, input sc_cfg_t c);
    logic [BYTE_W-1:0] b;
    logic [BYTE_W-1:0] r;
    b = (l ^ {BYTE_W{c.inv}}) & len_mask(c);
    for (int i = 0; i < BYTE_W; i++) r[c.msb ? BYTE_W-1-i : i] = b[i];
    return r;
  endfunction

  // Parity level over line levels, never inverted
  function automatic logic par_level(input logic [BYTE_W-1:0] l, input sc_cfg_t c);
    return (^(l & len_mask(c))) ^ c.odd;
  endfunction
endpackage

// File: rtl/sc_cfg_reg.sv
module sc_cfg_reg
  import sc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_i,
  input  logic    lock_i,
  input  sc_cfg_t cfg_i,
  output sc_cfg_t cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) cfg_o <= '0;
    else if (wr_i && !lock_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int BIT_CLKS  = 372,
  parameter int STOP_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sc_cfg_t           cfg,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam int FW = BYTE_W + 2 + STOP_BITS;
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0]     frame_w;
  logic [FW-1:0]     sh_q;
  logic [CW-1:0]     cnt_q;
  logic [NW-1:0]     bidx_q;
  logic [NW-1:0]     last_q;
  logic [NW-1:0]     last_w;
  logic [BYTE_W-1:0] lv_w;
  int                nbits;

  always_comb begin
    lv_w    = byte_to_line(data_i, cfg);
    nbits   = cfg.len7 ? BYTE_W - 1 : BYTE_W;
    frame_w = '1;
    frame_w[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < nbits) frame_w[1+i] = lv_w[i];
    frame_w[1+nbits] = par_level(lv_w, cfg);
    last_w = NW'(nbits + 1 + STOP_BITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b1;
      busy_o <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      bidx_q <= '0;
      last_q <= '0;
    end else if (!busy_o) begin
      if (start_i && cfg.en) begin
        busy_o <= 1'b1;
        line_o <= frame_w[0];
        sh_q   <= {1'b1, frame_w[FW-1:1]};
        cnt_q  <= '0;
        bidx_q <= '0;
        last_q <= last_w;
      end
    end else if (cnt_q == CW'(BIT_CLKS - 1)) begin
      cnt_q <= '0;
      if (bidx_q == last_q) begin
        busy_o <= 1'b0;
        line_o <= 1'b1;
      end else begin
        bidx_q <= bidx_q + 1'b1;
        line_o <= sh_q[0];
        sh_q   <= {1'b1, sh_q[FW-1:1]};
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
#(
  parameter int BIT_CLKS = 372
) (
  input  logic              clk,
  input  logic              rst,
  input  sc_cfg_t           cfg,
  input  logic              line_i,
  input  logic              rd_i,
  input  logic              perr_clr_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              idle_o
);
  localparam int CW   = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
  localparam int HALF = BIT_CLKS / 2;
  localparam int IW   = $clog2(BYTE_W);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_PAR} rx_st_t;

  rx_st_t            st_q;
  logic [2:0]        sy_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [BYTE_W-1:0] lv_q;
  logic              smp;
  logic              fall;
  logic [IW-1:0]     last_idx;

  assign smp      = sy_q[1];
  assign fall     = sy_q[2] & ~sy_q[1];
  assign last_idx = cfg.len7 ? IW'(BYTE_W - 2) : IW'(BYTE_W - 1);
  assign idle_o   = (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      sy_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      lv_q   <= '0;
      data_o <= '0;
      full_o <= 1'b0;
      perr_o <= 1'b0;
    end else begin
      sy_q <= {sy_q[1:0], line_i};
      if (rd_i) full_o <= 1'b0;
      if (perr_clr_i) perr_o <= 1'b0;
      case (st_q)
        S_IDLE: if (cfg.en && fall) begin
          st_q  <= S_START;
          cnt_q <= '0;
        end
        S_START: begin
          if (cnt_q == CW'(HALF - 1)) begin
            cnt_q <= '0;
            idx_q <= '0;
            lv_q  <= '0;
            st_q  <= smp ? S_IDLE : S_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_DATA: begin
          if (cnt_q == CW'(BIT_CLKS - 1)) begin
            cnt_q       <= '0;
            lv_q[idx_q] <= smp;
            if (idx_q == last_idx) st_q <= S_PAR;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == CW'(BIT_CLKS - 1)) begin
            cnt_q  <= '0;
            data_o <= line_to_byte(lv_q, cfg);
            full_o <= 1'b1;
            if (smp != par_level(lv_q, cfg)) perr_o <= 1'b1;
            st_q   <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_pkg::*;
#(
  parameter int BIT_CLKS  = 372,
  parameter int STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       cfg_msb,
  input  logic       cfg_inv,
  input  logic       cfg_len7,
  input  logic       cfg_odd,
  input  logic       tx_wr,
  input  logic [7:0] tx_byte,
  output logic       busy,
  output logic       line_out,
  input  logic       line_in,
  input  logic       rx_rd,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       perr,
  input  logic       perr_clr,
  output logic       st_en,
  output logic       st_msb,
  output logic       st_inv,
  output logic       st_len7,
  output logic       st_odd
);
  sc_cfg_t cfg_new;
  sc_cfg_t cfg_q;
  logic    rx_idle;

  assign cfg_new = '{en: cfg_en, msb: cfg_msb, inv: cfg_inv, len7: cfg_len7, odd: cfg_odd};

  sc_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (cfg_wr),
    .lock_i (busy | ~rx_idle),
    .cfg_i  (cfg_new),
    .cfg_o  (cfg_q)
  );

  sc_tx #(.BIT_CLKS(BIT_CLKS), .STOP_BITS(STOP_BITS)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg_q),
    .start_i (tx_wr),
    .data_i  (tx_byte),
    .line_o  (line_out),
    .busy_o  (busy)
  );

  sc_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg_q),
    .line_i     (line_in),
    .rd_i       (rx_rd),
    .perr_clr_i (perr_clr),
    .data_o     (rx_byte),
    .full_o     (rx_full),
    .perr_o     (perr),
    .idle_o     (rx_idle)
  );

  assign st_en   = cfg_q.en;
  assign st_msb  = cfg_q.msb;
  assign st_inv  = cfg_q.inv;
  assign st_len7 = cfg_q.len7;
  assign st_odd  = cfg_q.odd;
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic line_out,
  input logic rx_rd,
  input logic rx_full,
  input logic perr,
  input logic perr_clr,
  input logic st_en,
  input logic st_msb,
  input logic st_inv,
  input logic st_len7,
  input logic st_odd
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> line_out);

  // R9
  start_bit_low_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !line_out);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({st_en, st_msb, st_inv, st_len7, st_odd}));

  // R7
  full_clear_by_read_chk: assert property (@(posedge clk) disable iff (rst) $fell(rx_full) |-> $past(rx_rd));

  // R8
  perr_sticky_chk: assert property (@(posedge clk) disable iff (rst) $fell(perr) |-> $past(perr_clr));

  // R11
  disabled_no_tx_chk: assert property (@(posedge clk) disable iff (rst) (!st_en && !busy) |=> !busy);
endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .line_out (line_out),
  .rx_rd    (rx_rd),
  .rx_full  (rx_full),
  .perr     (perr),
  .perr_clr (perr_clr),
  .st_en    (st_en),
  .st_msb   (st_msb),
  .st_inv   (st_inv),
  .st_len7  (st_len7),
  .st_odd   (st_odd)
);

// File: tb/sc_char_xcvr_tb.sv
module sc_char_xcvr_tb;
  localparam int B = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 0, cfg_en = 0, cfg_msb = 0, cfg_inv = 0, cfg_len7 = 0, cfg_odd = 0;
  logic tx_wr = 0;
  logic [7:0] tx_byte = '0;
  logic busy, line_out, rx_full, perr;
  logic line_in = 1'b1;
  logic rx_rd = 0, perr_clr = 0;
  logic [7:0] rx_byte;
  logic st_en, st_msb, st_inv, st_len7, st_odd;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sc_char_xcvr #(.BIT_CLKS(B), .STOP_BITS(2)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_msb(cfg_msb),
    .cfg_inv(cfg_inv), .cfg_len7(cfg_len7), .cfg_odd(cfg_odd), .tx_wr(tx_wr),
    .tx_byte(tx_byte), .busy(busy), .line_out(line_out), .line_in(line_in),
    .rx_rd(rx_rd), .rx_byte(rx_byte), .rx_full(rx_full), .perr(perr),
    .perr_clr(perr_clr), .st_en(st_en), .st_msb(st_msb), .st_inv(st_inv),
    .st_len7(st_len7), .st_odd(st_odd)
  );

  // {msb, inv, len7, odd, tx byte, expected line levels in send order, parity level, expected stored byte}
  localparam logic [28:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0, 8'hA5},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h07, 8'hF8, 1'b1, 8'h07},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h3B, 8'hDC, 1'b0, 8'h3B},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h3F, 8'h03, 1'b0, 8'h3F},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 8'h7E, 1'b0, 8'h01},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h43, 1'b1, 8'hC2},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h80, 8'h7E, 1'b1, 8'h80},
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic msb, input logic inv, input logic len7, input logic odd);
    cfg_en = en; cfg_msb = msb; cfg_inv = inv; cfg_len7 = len7; cfg_odd = odd;
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic [7:0] lv, input int n, input logic par, input bit poke);
    tx_byte = d;
    tx_wr   = 1'b1;
    tick();
    tx_wr   = 1'b0;
    for (int k = 0; k < B / 2; k++) begin
      if (poke && k == 0) begin
        tx_wr = 1'b1; tx_byte = 8'h00; cfg_wr = 1'b1; cfg_inv = ~st_inv;
      end
      tick();
      tx_wr = 1'b0; cfg_wr = 1'b0;
    end
    check("R2 start bit low", line_out, 1'b0);
    check("R9 busy during frame", busy, 1'b1);
    for (int i = 0; i < n; i++) begin
      repeat (B) tick();
      check("R3 data bit level", line_out, lv[i]);
    end
    repeat (B) tick();
    check("R6 parity bit level", line_out, par);
    for (int s = 0; s < 2; s++) begin
      repeat (B) tick();
      check("R2 stop period high", line_out, 1'b1);
    end
    repeat (B) tick();
    check("R9 busy low after frame", busy, 1'b0);
  endtask

  task automatic send_rx(input logic [7:0] lv, input int n, input logic par);
    line_in = 1'b0;
    repeat (B) tick();
    for (int i = 0; i < n; i++) begin
      line_in = lv[i];
      repeat (B) tick();
    end
    line_in = par;
    repeat (B) tick();
    line_in = 1'b1;
    repeat (2 * B) tick();
  endtask

  task automatic read_rx();
    rx_rd = 1'b1;
    tick();
    rx_rd = 1'b0;
    check("R7 rx_full cleared by read", rx_full, 1'b0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      nerr = nerr + 1;
      nchk = nchk + 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check("R1 line idle high", line_out, 1'b1);
    check("R1 busy low", busy, 1'b0);
    check("R1 rx_full low", rx_full, 1'b0);
    check("R1 perr low", perr, 1'b0);
    check("R1 cfg readback zero", {st_en, st_msb, st_inv, st_len7, st_odd}, 5'b0);

    // R11 disabled: transmit and receive both inert
    tx_byte = 8'h5A; tx_wr = 1'b1; tick(); tx_wr = 1'b0;
    repeat (2 * B) tick();
    check("R11 no frame when disabled (busy)", busy, 1'b0);
    check("R11 no frame when disabled (line)", line_out, 1'b1);
    send_rx(8'hA5, 8, 1'b1);
    check("R11 no receive when disabled", rx_full, 1'b0);
    check("R11 no parity flag when disabled", perr, 1'b0);

    // Vector table across orders, inversion, lengths and parity sense
    for (int v = 0; v < 8; v++) begin
      logic [28:0] e;
      int n;
      e = VEC[v];
      n = e[26] ? 7 : 8;
      set_cfg(1'b1, e[28], e[27], e[26], e[25]);
      check("R10 cfg loaded when idle", {st_en, st_msb, st_inv, st_len7, st_odd}, {1'b1, e[28:25]});
      tx_frame(e[24:17], e[16:9], n, e[8], 1'b0);
      send_rx(e[16:9], n, e[8]);
      check("R7 rx_full set", rx_full, 1'b1);
      check("R4 R5 stored byte", rx_byte, e[7:0]);
      check("R6 good parity no error", perr, 1'b0);
      read_rx();
    end

    // R9 R10: transmit write and control write during a frame are dropped
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    tx_frame(8'hA5, 8'hA5, 8, 1'b0, 1'b1);
    check("R10 cfg write ignored mid-frame", st_inv, 1'b0);
    repeat (12 * B) tick();
    check("R9 no second frame from dropped write", busy, 1'b0);
    check("R9 line stays idle", line_out, 1'b1);

    // R8 parity error is sticky until cleared
    send_rx(8'hA5, 8, 1'b1);
    check("R8 bad parity sets perr", perr, 1'b1);
    check("R7 byte stored despite bad parity", rx_byte, 8'hA5);
    read_rx();
    send_rx(8'h0F, 8, 1'b0);
    check("R8 perr held through good char", perr, 1'b1);
    check("R3 LSB-first stored byte", rx_byte, 8'h0F);
    read_rx();
    perr_clr = 1'b1; tick(); perr_clr = 1'b0;
    check("R8 perr cleared by strobe", perr, 1'b0);

    // R4 seven-bit LSB-first: bit 7 of the byte is not sent
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    tx_frame(8'h80, 8'h00, 7, 1'b0, 1'b0);
    send_rx(8'h7F, 7, 1'b1);
    check("R4 seven-bit LSB-first top bit zero", rx_byte, 8'h7F);
    read_rx();

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule